// File: doc/BRIEF.md
# Dual-Scheme SPI Bit-Clock Divider

This block turns the bus clock into the bit-rate timing for an SPI serial engine. It produces two outputs. The first is a one-cycle toggle strobe at every half period of the serial clock. The second is the divided clock level, which flips on each strobe. A mode input picks one of two division schemes. In the power-of-two scheme a small exponent code gives a ratio of 2^(code+1). In the linear scheme an 8-bit code gives an even ratio of 2*(code+1) bus cycles.

The divider code and the mode are captured only while the engine enable is low. Once the engine is enabled, those inputs may change freely without disturbing a running transfer. The half-period counter reloads whenever the divider is not running, and that covers both a fresh setting and the start of a transfer. As a result the first half period of every transfer has its full length.

Top module: `spi_sclk_div`

## Requirements
- R1: After reset, with enable and transfer-active held low, `tgl_o` and `sclk_o` are both 0.
- R2: With mode 0 (power-of-two scheme), strobes on `tgl_o` are 2^code bus cycles apart, so the clock period is 2^(code+1) cycles.
- R3: In mode 0, any code above 15 behaves as code 15, giving strobes 32768 cycles apart.
- R4: With mode 1 (linear scheme), strobes are code+1 cycles apart, so the clock period is 2*(code+1) cycles. Code 0 gives a strobe on every cycle.
- R5: Mode and code are captured on every clock edge at which `en_i` is 0. Changes made to them while `en_i` is 1 do not affect the strobe spacing.
- R6: The first strobe of a transfer comes exactly one half period after the divider starts running. The first running cycle is counted as cycle 1. This holds even if an earlier transfer was stopped partway through a half period.
- R7: While `en_i` or `active_i` is 0, `tgl_o` stays 0, and `sclk_o` returns to 0 on the next edge.
- R8: While running, `sclk_o` inverts on the edge that ends each strobe cycle and holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Engine enable; setting is captured while low |
| mode_i | input | 1 | Division scheme: 0 power-of-two, 1 linear |
| code_i | input | LIN_W (8) | Divider code |
| active_i | input | 1 | Transfer in progress |
| tgl_o | output | 1 | One-cycle strobe at each half period |
| sclk_o | output | 1 | Divided clock level, idle low |

## Verification
The bench builds the block with its default parameters: an 8-bit code and a largest exponent of 15. With these values the clamped power-of-two case is reachable, and its 32768-cycle half period is measured exactly. The same build reaches the one-cycle extreme of the linear scheme and the 256-cycle top of its range. Strobe spacing is timed from the start of each transfer. This exposes both the reload on start and the rule that settings are ignored while enabled.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
  import spi_div_pkg::*;
#(
  parameter int LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [LIN_W-1:0] code_i,
  output div_mode_e        mode_o,
  output logic [LIN_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= DIV_POW2;
      code_o <= '0;
    end else if (!en_i) begin
      mode_o <= div_mode_e'(mode_i);
      code_o <= code_i;
    end
  end
endmodule

// File: rtl/spi_div_decode.sv
module spi_div_decode
  import spi_div_pkg::*;
#(
  parameter int LIN_W   = 8,
  parameter int EXP_MAX = 15,
  parameter int CNT_W   = 15
) (
  input  div_mode_e        mode_i,
  input  logic [LIN_W-1:0] code_i,
  output logic [CNT_W-1:0] half_m1_o
);
  logic [LIN_W-1:0] exp_c;
  logic [CNT_W-1:0] pow_m1;
  logic [CNT_W-1:0] lin_m1;

  always_comb begin
    // clamp exponent to the largest supported value
    exp_c  = (code_i > LIN_W'(EXP_MAX)) ? LIN_W'(EXP_MAX) : code_i;
    pow_m1 = (CNT_W'(1) << exp_c) - CNT_W'(1);
    lin_m1 = CNT_W'(code_i);
    half_m1_o = (mode_i == DIV_LIN) ? lin_m1 : pow_m1;
  end
endmodule

// File: rtl/spi_div_cnt.sv
module spi_div_cnt #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_m1_i,
  output logic             tgl_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || cnt_q == '0) cnt_q <= half_m1_i;
    else                           cnt_q <= cnt_q - CNT_W'(1);
  end

  assign tgl_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import spi_div_pkg::*;
#(
  parameter int LIN_W   = 8,
  parameter int EXP_MAX = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [LIN_W-1:0] code_i,
  input  logic             active_i,
  output logic             tgl_o,
  output logic             sclk_o
);
  localparam int CNT_W = max_int(EXP_MAX, LIN_W);

  div_mode_e        cfg_mode;
  logic [LIN_W-1:0] cfg_code;
  logic [CNT_W-1:0] half_m1;
  logic             run;
  logic             tgl;
  logic             sclk_q;

  assign run = en_i & active_i;

  spi_div_cfg #(.LIN_W(LIN_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .code_i (code_i),
    .mode_o (cfg_mode),
    .code_o (cfg_code)
  );

  spi_div_decode #(.LIN_W(LIN_W), .EXP_MAX(EXP_MAX), .CNT_W(CNT_W)) u_dec (
    .mode_i    (cfg_mode),
    .code_i    (cfg_code),
    .half_m1_o (half_m1)
  );

  spi_div_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .half_m1_i (half_m1),
    .tgl_o     (tgl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sclk_q <= 1'b0;
    else if (!run) sclk_q <= 1'b0;
    else if (tgl)  sclk_q <= ~sclk_q;
  end

  assign tgl_o  = tgl;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_sclk_div_chk.sv
module spi_sclk_div_chk #(
  parameter int LIN_W   = 8,
  parameter int EXP_MAX = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             active_i,
  input logic             tgl_o,
  input logic             sclk_o,
  input logic             cfg_mode,
  input logic [LIN_W-1:0] cfg_code
);
  localparam int GAP_W   = EXP_MAX + 2;
  localparam int MAX_GAP = (1 << EXP_MAX) - 1;

  logic             run;
  logic [GAP_W-1:0] gap_q;

  assign run = en_i & active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= '0;
    else if (!run || tgl_o) gap_q <= '0;
    else                   gap_q <= gap_q + GAP_W'(1);
  end

  AST_IDLE_NO_TGL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !tgl_o) else $error("idle strobe"); // R7
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !sclk_o) else $error("sclk not idle"); // R7
  AST_TGL_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgl_o |=> (sclk_o != $past(sclk_o))) else $error("no flip"); // R8
  AST_SCLK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tgl_o) |=> $stable(sclk_o)) else $error("spurious flip"); // R8
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && gap_q >= GAP_W'(MAX_GAP)) |-> tgl_o) else $error("gap too long"); // R3
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ($stable(cfg_code) && $stable(cfg_mode))) else $error("cfg moved"); // R5
  AST_LIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cfg_mode && cfg_code == '0) |-> tgl_o) else $error("lin0 miss"); // R4
endmodule

bind spi_sclk_div spi_sclk_div_chk #(.LIN_W(LIN_W), .EXP_MAX(EXP_MAX)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .active_i (active_i),
  .tgl_o    (tgl_o),
  .sclk_o   (sclk_o),
  .cfg_mode (cfg_mode),
  .cfg_code (cfg_code)
);

// File: tb/spi_sclk_div_test.sv
module spi_sclk_div_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [7:0] code_i = '0;
  logic       active_i = 1'b0;
  logic       tgl_o, sclk_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  spi_sclk_div uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .code_i(code_i), .active_i(active_i), .tgl_o(tgl_o), .sclk_o(sclk_o)
  );

  // {mode, code, expected half period}
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'd0,   16'd1},
    {1'b0, 8'd1,   16'd2},
    {1'b0, 8'd3,   16'd8},
    {1'b0, 8'd7,   16'd128},
    {1'b1, 8'd0,   16'd1},
    {1'b1, 8'd1,   16'd2},
    {1'b1, 8'd9,   16'd10},
    {1'b1, 8'd255, 16'd256},
    {1'b0, 8'd10,  16'd1024},
    {1'b0, 8'd200, 16'd32768}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic m, input logic [7:0] c);
    active_i = 1'b0;
    en_i = 1'b0; mode_i = m; code_i = c;
    @(negedge clk);
    en_i = 1'b1;
    @(negedge clk);
  endtask

  // starts a transfer at a negedge, returns first strobe cycle and gap to second
  task automatic measure(input int limit, output int first, output int second, output bit tog_ok);
    int c = 0;
    int hits = 0;
    logic p_tgl = 1'b0;
    logic p_sclk = 1'b0;
    first = 0; second = 0; tog_ok = 1'b1;
    active_i = 1'b1;
    while (hits < 2 && c < limit) begin
      #2;
      c++;
      if (c > 1 && p_tgl && sclk_o == p_sclk) tog_ok = 1'b0;
      if (c > 1 && !p_tgl && sclk_o != p_sclk) tog_ok = 1'b0;
      if (tgl_o) begin
        hits++;
        if (hits == 1) first = c; else second = c - first;
      end
      p_tgl = tgl_o; p_sclk = sclk_o;
      @(negedge clk);
    end
    active_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    chk(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f, s;
    bit tok;
    repeat (2) @(negedge clk);
    #2;
    chk(tgl_o == 1'b0, "R1 tgl", tgl_o, 0);
    chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #2;
    chk(tgl_o == 1'b0 && sclk_o == 1'b0, "R1 after release", {tgl_o, sclk_o}, 0);
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic m;
      logic [7:0] c;
      int h;
      string rq;
      m = VEC[i][24]; c = VEC[i][23:16]; h = int'(VEC[i][15:0]);
      rq = m ? "R4" : ((c > 8'd15) ? "R3" : "R2");
      set_cfg(m, c);
      measure(70000, f, s, tok);
      chk(f == h, {rq, " first R6"}, f, h);
      chk(s == h, rq, s, h);
      chk(tok, "R8 toggle", tok, 1);
    end

    // R5: changes while enabled are ignored
    set_cfg(1'b1, 8'd3);
    mode_i = 1'b0; code_i = 8'd0;
    @(negedge clk);
    measure(100, f, s, tok);
    chk(f == 4, "R5 first", f, 4);
    chk(s == 4, "R5 gap", s, 4);

    // R5: new setting captured once enable drops
    set_cfg(1'b1, 8'd5);
    measure(100, f, s, tok);
    chk(s == 6, "R5 recapture", s, 6);

    // R6: restart after partial half period
    set_cfg(1'b1, 8'd4);
    active_i = 1'b1;
    repeat (3) @(negedge clk);
    active_i = 1'b0;
    @(negedge clk);
    measure(100, f, s, tok);
    chk(f == 5, "R6 restart first", f, 5);

    // R7: enabled but idle, and active but disabled
    set_cfg(1'b1, 8'd0);
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        #2;
        if (tgl_o || sclk_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R7 idle enabled", seen, 0);
      en_i = 1'b0; active_i = 1'b1;
      seen = 0;
      for (int k = 0; k < 20; k++) begin
        #2;
        if (tgl_o || sclk_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R7 disabled active", seen, 0);
      en_i = 1'b1;
      #2;
      chk(tgl_o == 1'b1, "R4 code0 strobe", tgl_o, 1);
      @(negedge clk);
      active_i = 1'b0;
      @(negedge clk);
      #2;
      chk(sclk_o == 1'b0, "R7 sclk returns low", sclk_o, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule